// File: doc/BRIEF.md
# SMBus Control Flag Update Unit

This block keeps the eight control and status flags of a two-wire serial bus controller and updates them every clock. The bit-level bus engine reports what happened on the wire as single-cycle event pulses: a START generated or detected, a repeated START, an address received, a STOP detected or generated, a frame beginning, a byte sent or received, an ACK slot finished or sampled, and a bus line found low while the controller was driving it. Software reaches the flags through a write strobe with a data byte, and through a strobe that marks a write of the data register.

Each flag has its own rules for being set and cleared. Arbitration loss can be caused in three ways. Clearing the interrupt flag from software also clears the arbitration-lost flag. The interrupt output is the interrupt flag gated by an enable input.

Flag layout in `flags`: bit 0 interrupt, bit 1 acknowledge, bit 2 stop, bit 3 start request, bit 4 ACK request, bit 5 arbitration lost, bit 6 transmit mode, bit 7 master.

Top module: `smbFlagUnit`

## Requirements
- R1: On a synchronous active-high `rst`, all eight flags become 0 and `irqOut` is 0.
- R2: Master (bit 7) is set one cycle after `evStartGen`. It is cleared after `evStopGen` or after any arbitration loss.
- R3: Transmit mode (bit 6) is set after `evStartGen`. It is also set on `evFrameStart` if `dataWrite` was pulsed since the previous frame start or in the same cycle. It is cleared on `evFrameStart` with no such write, on `evStartDet`, or on arbitration loss.
- R4: Start request (bit 3) is set after `evAddrRcvd`. No hardware event clears it. Only a software write changes it back.
- R5: Stop (bit 4... see layout: bit 2) is set after `evStopDet` while `slaveAddressed` is high, or after `evStopDet` in a cycle that loses arbitration. It is cleared after `evStopGen`.
- R6: ACK request (bit 4) is set after `evByteRcvd` only while `hwAckEn` is 0. It is cleared after `evAckCycle`.
- R7: Arbitration lost (bit 5) is set in three cases: `evRepStart` while master is 1 and start request is 0; `sclLowDrive`; or `sdaLowOne`.
- R8: On `ackStrobe`, acknowledge (bit 1) becomes the inverse of `ackLevel`: 1 for a low ACK, 0 for a high NACK.
- R9: Interrupt (bit 0) is set after `evStartGen`, arbitration loss, `evByteSent`, `evByteRcvd`, `evAddrRcvd` or `evStopDet`. Only software clears it.
- R10: When a hardware set and a hardware clear of one flag fall in the same cycle, the flag becomes 1. A software write to a writable flag in that cycle overrides both.
- R11: A `swWrite` loads bits 1, 2 and 3 from `swData`. It clears the interrupt flag when `swData[0]` is 0, and writing 1 to that bit has no effect. A write that clears the interrupt flag also clears arbitration lost. Writes to bits 4 to 7 have no effect.
- R12: `irqOut` is 1 exactly when the interrupt flag is 1 and `irqEnable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evStartGen | input | 1 | Controller generated a START |
| evStartDet | input | 1 | A START was detected on the bus |
| evRepStart | input | 1 | A repeated START was detected |
| evAddrRcvd | input | 1 | A START (or repeated START) and a slave address with R/W were received |
| evStopDet | input | 1 | A STOP was detected |
| evStopGen | input | 1 | Controller generated a STOP |
| evFrameStart | input | 1 | A new bus frame begins |
| evByteSent | input | 1 | A byte was sent and its ACK/NACK received |
| evByteRcvd | input | 1 | A byte was received |
| evAckCycle | input | 1 | An ACK cycle has finished |
| ackStrobe | input | 1 | Sampled ACK bit is valid |
| ackLevel | input | 1 | Sampled ACK line level |
| sclLowDrive | input | 1 | SCL was found low while generating a STOP or a repeated START |
| sdaLowOne | input | 1 | SDA was found low while sending a 1 (ACK bits excluded) |
| slaveAddressed | input | 1 | Device is currently addressed as a slave |
| hwAckEn | input | 1 | Hardware ACK generation is enabled |
| dataWrite | input | 1 | Software wrote the data register |
| swWrite | input | 1 | Software write of the flag register |
| swData | input | 8 | Data for the software write |
| irqEnable | input | 1 | Interrupt output enable |
| flags | output | 8 | Flag register |
| irqOut | output | 1 | Gated interrupt |

## Verification
The assertions check on every cycle the rules that hold whatever else happens: a START generated sets master, the interrupt and start-request flags stay set until software acts, the two line-sensing causes of arbitration loss set their flag, a software clear of the interrupt clears arbitration lost, and the acknowledge flag follows the sampled ACK. Only the bench's scenarios can show the rules that depend on history or on timing between events. These are the frame-start decision for transmit mode, which depends on an earlier data write; the repeated START rule, which depends on the master and start-request state; the outcome when a set, a clear and a software write arrive together; and that writes to the read-only flags leave them unchanged.

// File: rtl/smbFlagPkg.sv
package smbFlagPkg;
  localparam int FLAG_W = 8;
  localparam int SW_W   = 8;

  localparam int IDX_IRQ   = 0;
  localparam int IDX_ACK   = 1;
  localparam int IDX_STOP  = 2;
  localparam int IDX_STREQ = 3;
  localparam int IDX_ACKRQ = 4;
  localparam int IDX_ARB   = 5;
  localparam int IDX_TX    = 6;
  localparam int IDX_MST   = 7;

  typedef struct packed {
    logic [FLAG_W-1:0] hwSet;
    logic [FLAG_W-1:0] hwClr;
    logic [FLAG_W-1:0] swMask;
    logic [FLAG_W-1:0] swVal;
  } flagStrobes_t;
endpackage

// File: rtl/smbFlagCtrl.sv
module smbFlagCtrl
  import smbFlagPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evStartGen,
  input  logic              evStartDet,
  input  logic              evRepStart,
  input  logic              evAddrRcvd,
  input  logic              evStopDet,
  input  logic              evStopGen,
  input  logic              evFrameStart,
  input  logic              evByteSent,
  input  logic              evByteRcvd,
  input  logic              evAckCycle,
  input  logic              ackStrobe,
  input  logic              ackLevel,
  input  logic              sclLowDrive,
  input  logic              sdaLowOne,
  input  logic              slaveAddressed,
  input  logic              hwAckEn,
  input  logic              dataWrite,
  input  logic              swWrite,
  input  logic [SW_W-1:0]   swData,
  input  logic [FLAG_W-1:0] flagsQ,
  output flagStrobes_t      strobes
);
  logic wrPending;
  logic wroteForFrame;
  logic arbLost;
  logic swIrqClear;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPending <= 1'b0;
    end else if (evFrameStart) begin
      wrPending <= 1'b0;
    end else if (dataWrite) begin
      wrPending <= 1'b1;
    end
  end

  assign wroteForFrame = wrPending | dataWrite;
  assign arbLost = (evRepStart & flagsQ[IDX_MST] & ~flagsQ[IDX_STREQ])
                 | sclLowDrive | sdaLowOne;
  assign swIrqClear = swWrite & ~swData[IDX_IRQ];

  always_comb begin
    strobes = '0;
    strobes.hwSet[IDX_MST]   = evStartGen;
    strobes.hwClr[IDX_MST]   = evStopGen | arbLost;

    strobes.hwSet[IDX_TX]    = evStartGen | (evFrameStart & wroteForFrame);
    strobes.hwClr[IDX_TX]    = evStartDet | arbLost | (evFrameStart & ~wroteForFrame);

    strobes.hwSet[IDX_STREQ] = evAddrRcvd;

    strobes.hwSet[IDX_STOP]  = evStopDet & (slaveAddressed | arbLost);
    strobes.hwClr[IDX_STOP]  = evStopGen;

    strobes.hwSet[IDX_ACKRQ] = evByteRcvd & ~hwAckEn;
    strobes.hwClr[IDX_ACKRQ] = evAckCycle;

    strobes.hwSet[IDX_ARB]   = arbLost;

    strobes.hwSet[IDX_ACK]   = ackStrobe & ~ackLevel;
    strobes.hwClr[IDX_ACK]   = ackStrobe & ackLevel;

    strobes.hwSet[IDX_IRQ]   = evStartGen | arbLost | evByteSent | evByteRcvd
                             | evAddrRcvd | evStopDet;

    strobes.swMask[IDX_STREQ] = swWrite;
    strobes.swMask[IDX_STOP]  = swWrite;
    strobes.swMask[IDX_ACK]   = swWrite;
    strobes.swMask[IDX_IRQ]   = swIrqClear;
    strobes.swMask[IDX_ARB]   = swIrqClear;
    strobes.swVal[IDX_STREQ]  = swData[IDX_STREQ];
    strobes.swVal[IDX_STOP]   = swData[IDX_STOP];
    strobes.swVal[IDX_ACK]    = swData[IDX_ACK];
  end
endmodule

// File: rtl/smbFlagRegs.sv
module smbFlagRegs
  import smbFlagPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  flagStrobes_t      strobes,
  output logic [FLAG_W-1:0] flagsQ
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flagsQ[i] <= 1'b0;
      end else if (strobes.swMask[i]) begin
        flagsQ[i] <= strobes.swVal[i];
      end else if (strobes.hwSet[i]) begin
        flagsQ[i] <= 1'b1;
      end else if (strobes.hwClr[i]) begin
        flagsQ[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smbFlagUnit.sv
module smbFlagUnit
  import smbFlagPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evStartGen,
  input  logic              evStartDet,
  input  logic              evRepStart,
  input  logic              evAddrRcvd,
  input  logic              evStopDet,
  input  logic              evStopGen,
  input  logic              evFrameStart,
  input  logic              evByteSent,
  input  logic              evByteRcvd,
  input  logic              evAckCycle,
  input  logic              ackStrobe,
  input  logic              ackLevel,
  input  logic              sclLowDrive,
  input  logic              sdaLowOne,
  input  logic              slaveAddressed,
  input  logic              hwAckEn,
  input  logic              dataWrite,
  input  logic              swWrite,
  input  logic [SW_W-1:0]   swData,
  input  logic              irqEnable,
  output logic [FLAG_W-1:0] flags,
  output logic              irqOut
);
  flagStrobes_t strobes;
  logic [FLAG_W-1:0] flagsQ;

  smbFlagCtrl u_ctrl (
    .clk(clk), .rst(rst),
    .evStartGen(evStartGen), .evStartDet(evStartDet), .evRepStart(evRepStart),
    .evAddrRcvd(evAddrRcvd), .evStopDet(evStopDet), .evStopGen(evStopGen),
    .evFrameStart(evFrameStart), .evByteSent(evByteSent), .evByteRcvd(evByteRcvd),
    .evAckCycle(evAckCycle), .ackStrobe(ackStrobe), .ackLevel(ackLevel),
    .sclLowDrive(sclLowDrive), .sdaLowOne(sdaLowOne),
    .slaveAddressed(slaveAddressed), .hwAckEn(hwAckEn), .dataWrite(dataWrite),
    .swWrite(swWrite), .swData(swData), .flagsQ(flagsQ), .strobes(strobes)
  );

  smbFlagRegs u_regs (
    .clk(clk), .rst(rst), .strobes(strobes), .flagsQ(flagsQ)
  );

  assign flags  = flagsQ;
  assign irqOut = flagsQ[IDX_IRQ] & irqEnable;
endmodule

// File: rtl/smbFlagChk.sv
module smbFlagChk
  import smbFlagPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              evStartGen,
  input logic              evAddrRcvd,
  input logic              ackStrobe,
  input logic              ackLevel,
  input logic              sclLowDrive,
  input logic              sdaLowOne,
  input logic              swWrite,
  input logic [SW_W-1:0]   swData,
  input logic [FLAG_W-1:0] flags
);
  logic swIrqClr;
  assign swIrqClr = swWrite & ~swData[IDX_IRQ];

  assert_master_set_R2: assert property (@(posedge clk) disable iff (rst)
    evStartGen |=> flags[IDX_MST]);

  assert_streq_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (flags[IDX_STREQ] && !swWrite) |=> flags[IDX_STREQ]);

  assert_arb_line_R7: assert property (@(posedge clk) disable iff (rst)
    ((sclLowDrive || sdaLowOne) && !swIrqClr) |=> flags[IDX_ARB]);

  assert_ack_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (ackStrobe && !swWrite) |=> (flags[IDX_ACK] == !$past(ackLevel)));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (flags[IDX_IRQ] && !swIrqClr) |=> flags[IDX_IRQ]);

  assert_arb_clear_R11: assert property (@(posedge clk) disable iff (rst)
    swIrqClr |=> (!flags[IDX_ARB] && !flags[IDX_IRQ]));
endmodule

bind smbFlagUnit smbFlagChk u_chk (
  .clk(clk), .rst(rst), .evStartGen(evStartGen), .evAddrRcvd(evAddrRcvd),
  .ackStrobe(ackStrobe), .ackLevel(ackLevel), .sclLowDrive(sclLowDrive),
  .sdaLowOne(sdaLowOne), .swWrite(swWrite), .swData(swData), .flags(flags)
);

// File: tb/smbFlagUnit_tb.sv
module smbFlagUnit_tb;
  localparam int B_IRQ = 0, B_ACK = 1, B_STOP = 2, B_STREQ = 3;
  localparam int B_ACKRQ = 4, B_ARB = 5, B_TX = 6, B_MST = 7;

  logic clk = 1'b0;
  logic rst;
  logic evStartGen, evStartDet, evRepStart, evAddrRcvd, evStopDet, evStopGen;
  logic evFrameStart, evByteSent, evByteRcvd, evAckCycle, ackStrobe, ackLevel;
  logic sclLowDrive, sdaLowOne, slaveAddressed, hwAckEn, dataWrite, swWrite;
  logic [7:0] swData;
  logic irqEnable;
  logic [7:0] flags;
  logic irqOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  smbFlagUnit u_dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    evStartGen = 0; evStartDet = 0; evRepStart = 0; evAddrRcvd = 0;
    evStopDet = 0; evStopGen = 0; evFrameStart = 0; evByteSent = 0;
    evByteRcvd = 0; evAckCycle = 0; ackStrobe = 0; ackLevel = 0;
    sclLowDrive = 0; sdaLowOne = 0; dataWrite = 0; swWrite = 0; swData = 8'h00;
  endtask

  // inputs were set after a negedge; one posedge latches them; sample at next negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic doReset();
    rst = 1; idle();
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic swClearIrq();
    swWrite = 1; swData = 8'h00; step();
  endtask

  task automatic testReset();
    doReset();
    check("R1 flags after reset", flags, 8'h00);
    check("R1 irqOut after reset", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testMaster();
    doReset();
    evStartGen = 1; step();
    check("R2 master/tx/irq on start gen", flags, 8'b1100_0001);
    swClearIrq();
    evStopGen = 1; step();
    check("R2 master cleared by stop gen", {7'b0, flags[B_MST]}, 8'h00);
    evStartGen = 1; step();
    swClearIrq();
    sdaLowOne = 1; step();
    check("R7 sda low loses arbitration", flags, 8'b0010_0001);
    swClearIrq();
    check("R11 irq clear clears arb lost", flags, 8'h00);
  endtask

  task automatic testTxMode();
    doReset();
    dataWrite = 1; step();
    step();
    evFrameStart = 1; step();
    check("R3 tx set after data write", {7'b0, flags[B_TX]}, 8'h01);
    evFrameStart = 1; step();
    check("R3 tx cleared with no data write", {7'b0, flags[B_TX]}, 8'h00);
    dataWrite = 1; evFrameStart = 1; step();
    check("R3 write in frame-start cycle counts", {7'b0, flags[B_TX]}, 8'h01);
    evStartDet = 1; step();
    check("R3 start detect clears tx", {7'b0, flags[B_TX]}, 8'h00);
  endtask

  task automatic testStartReq();
    doReset();
    evAddrRcvd = 1; step();
    check("R4 start request and irq on address", flags, 8'b0000_1001);
    evStopGen = 1; evStartDet = 1; evAckCycle = 1; step();
    check("R4 hardware leaves start request", {7'b0, flags[B_STREQ]}, 8'h01);
    swWrite = 1; swData = 8'h01; step();
    check("R4 software clears start request", flags, 8'b0000_0001);
  endtask

  task automatic testStop();
    doReset();
    slaveAddressed = 1; evStopDet = 1; step();
    check("R5 stop set while addressed", flags, 8'b0000_0101);
    evStopGen = 1; step();
    check("R5 stop gen clears stop", {7'b0, flags[B_STOP]}, 8'h00);
    swClearIrq();
    slaveAddressed = 0; evStopDet = 1; step();
    check("R9 stop received sets irq only", flags, 8'b0000_0001);
    swClearIrq();
    evStopDet = 1; sclLowDrive = 1; step();
    check("R5 stop with arbitration loss", flags, 8'b0010_0101);
  endtask

  task automatic testAckReq();
    doReset();
    hwAckEn = 0; evByteRcvd = 1; step();
    check("R6 ack request with hw ack off", flags, 8'b0001_0001);
    evAckCycle = 1; step();
    check("R6 ack cycle clears request", {7'b0, flags[B_ACKRQ]}, 8'h00);
    swClearIrq();
    hwAckEn = 1; evByteRcvd = 1; step();
    check("R6 no request with hw ack on", flags, 8'b0000_0001);
    hwAckEn = 0;
    swClearIrq();
    evByteSent = 1; step();
    check("R9 byte sent sets irq", flags, 8'b0000_0001);
  endtask

  task automatic testAck();
    doReset();
    ackStrobe = 1; ackLevel = 0; step();
    check("R8 low ack sets ack flag", flags, 8'b0000_0010);
    ackStrobe = 1; ackLevel = 1; step();
    check("R8 high ack clears ack flag", flags, 8'b0000_0000);
  endtask

  task automatic testRepStart();
    doReset();
    evStartGen = 1; step();
    swClearIrq();
    swWrite = 1; swData = 8'b0000_1001; step();
    evRepStart = 1; step();
    check("R7 repeated start with start request high", flags, 8'b1100_1000);
    swWrite = 1; swData = 8'b0000_0001; step();
    evRepStart = 1; step();
    check("R7 unwanted repeated start loses arbitration", flags, 8'b0010_0001);
    evRepStart = 1; step();
    check("R7 repeated start not master no new loss", {7'b0, flags[B_MST]}, 8'h00);
  endtask

  task automatic testPriority();
    doReset();
    evStartGen = 1; evStopGen = 1; step();
    check("R10 set wins over clear", {7'b0, flags[B_MST]}, 8'h01);
    slaveAddressed = 1; evStopDet = 1; swWrite = 1; swData = 8'h01; step();
    slaveAddressed = 0;
    check("R10 software beats stop set", {7'b0, flags[B_STOP]}, 8'h00);
    swWrite = 1; swData = 8'h00; evByteRcvd = 1; step();
    check("R10 software clear beats irq set", {7'b0, flags[B_IRQ]}, 8'h00);
  endtask

  task automatic testIgnored();
    doReset();
    swWrite = 1; swData = 8'hFF; step();
    check("R11 only bits 1..3 writable", flags, 8'b0000_1110);
    evStartGen = 1; step();
    swWrite = 1; swData = 8'h01; step();
    check("R11 write 1 to irq and 0 to master ignored", flags, 8'b1100_0001);
  endtask

  task automatic testIrqOut();
    doReset();
    irqEnable = 0; evByteSent = 1; step();
    check("R12 irq gated off", {7'b0, irqOut}, 8'h00);
    irqEnable = 1; #1;
    check("R12 irq enabled", {7'b0, irqOut}, 8'h01);
  endtask

  initial begin
    rst = 1; slaveAddressed = 0; hwAckEn = 0; irqEnable = 0; idle();
    testReset();
    testMaster();
    testTxMode();
    testStartReq();
    testStop();
    testAckReq();
    testAck();
    testRepStart();
    testPriority();
    testIgnored();
    testIrqOut();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule